// File: doc/BRIEF.md
# Fractional Two-Stage Pixel Clock Generator

This block derives a display pixel clock from the faster module clock in two cascaded stages. The first stage is a fractional divider. Its period is the integer divisor plus a fraction, numerator over denominator, spread over time by an accumulator. Each of its periods is cut into two halves, and the boundaries between halves form a stream of half events. The second stage is an integer prescaler. It counts these half events and flips the pixel clock level so that one pixel clock period spans `cfg_pre + 1` intermediate periods.

While the generator is gated off, the pixel clock rests at a programmable idle level. A second configuration bit picks whether data is launched on the rising or the falling pixel clock edge. Two one-cycle strobes, `launch_stb` and `sample_stb`, mark each edge for downstream shifters. Divider settings are captured only at pixel period boundaries, so a change never produces a shortened pulse. Control and configuration pins are plain levels. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `pixclk_gen`

## Requirements
- R1: While `rst_n` is low, `pclk`, `launch_stb` and `sample_stb` are all 0.
- R2: When `en` is sampled low, from the next clock edge `pclk` equals `cfg_idle_hi`, and neither strobe is high.
- R3: `cfg_err` is 1 when `cfg_int` < 2, or when `cfg_den` != 0 and `cfg_num` >= `cfg_den`. While it is set, the generator does not start, and `pclk` stays at the idle level.
- R4: When `cfg_den` or `cfg_num` is 0, every intermediate period is exactly `cfg_int` module clock cycles.
- R5: Otherwise an accumulator, which starts at 0, adds `cfg_num` once per intermediate period. When the sum reaches or exceeds `cfg_den`, `cfg_den` is subtracted and that period lasts `cfg_int + 1` cycles; otherwise it lasts `cfg_int` cycles.
- R6: An intermediate period of L cycles yields a first half event ceil(L/2) cycles after its start and a second half event at its end, floor(L/2) cycles later. The first period starts at the clock edge that samples `en` high.
- R7: Counting half events from 0 after start, `pclk` changes level at the edge that ends half event number k whenever k mod (2·(`cfg_pre`+1)) equals `cfg_pre` or 2·`cfg_pre`+1. The first level from start is the idle level.
- R8: `launch_stb` is high for exactly the cycle in which `pclk` has just changed to the launch level: 1 when `cfg_launch_fall` = 0, and 0 when it is 1. `sample_stb` is high for the cycle after each change to the other level. The two strobes are never high together.
- R9: Changes to `cfg_int`, `cfg_num`, `cfg_den`, `cfg_pre` or `cfg_launch_fall` take effect only at the end of a pixel period. When any of these changes, the accumulator restarts at 0.
- R10: The largest prescale, `cfg_pre` = 63 (divide by 64), is supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Generator enable; low gates the output to idle |
| cfg_int | input | INT_W | Integer divisor, at least 2 |
| cfg_num | input | FRAC_W | Fraction numerator |
| cfg_den | input | FRAC_W | Fraction denominator; 0 disables dithering |
| cfg_pre | input | PRE_W | Prescale minus one |
| cfg_idle_hi | input | 1 | Idle level of the pixel clock |
| cfg_launch_fall | input | 1 | 1: launch on the falling edge, 0: on the rising edge |
| cfg_err | output | 1 | Current configuration is illegal |
| pclk | output | 1 | Pixel clock level |
| launch_stb | output | 1 | One-cycle mark of a launch edge |
| sample_stb | output | 1 | One-cycle mark of the opposite edge |

## Verification
A half event found at a clock edge becomes visible on `pclk` one edge later. The strobe rises in that same cycle, so the bench models each level change as a cycle gap measured from the previous change. The first gap is measured from the edge that samples `en` high. A monitor samples the outputs on the falling clock edge and pops the next expected gap each time `pclk` changes. The driver acts one nanosecond after that falling edge, so a stop or a configuration change always lands before the next active edge. Dropping `en` is checked one edge later.

// File: rtl/pixclk_pkg.sv
package pixclk_pkg;
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_MID  = 2'd1,
    EV_END  = 2'd2
  } half_ev_e;
endpackage

// File: rtl/pixclk_cfg_chk.sv
module pixclk_cfg_chk #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 6
) (
  input  logic [INT_W-1:0]  cfg_int,
  input  logic [FRAC_W-1:0] cfg_num,
  input  logic [FRAC_W-1:0] cfg_den,
  output logic              cfg_bad
);
  localparam logic [INT_W-1:0] MIN_INT = INT_W'(2);

  logic int_low, frac_over;

  always_comb begin
    int_low   = (cfg_int < MIN_INT);
    frac_over = (cfg_den != '0) && (cfg_num >= cfg_den);
    cfg_bad   = int_low || frac_over;
  end
endmodule

// File: rtl/pixclk_frac_div.sv
module pixclk_frac_div
  import pixclk_pkg::*;
#(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 6,
  parameter int PRE_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [INT_W-1:0]  cfg_int,
  input  logic [FRAC_W-1:0] cfg_num,
  input  logic [FRAC_W-1:0] cfg_den,
  input  logic [PRE_W-1:0]  cfg_pre,
  input  logic              cfg_launch_fall,
  input  logic              cfg_bad,
  input  logic              pix_bound,
  output logic              active,
  output half_ev_e          ev,
  output logic [PRE_W-1:0]  pre_q,
  output logic              lf_q
);
  localparam int LEN_W = INT_W + 1;
  localparam int SUM_W = FRAC_W + 1;

  logic [LEN_W-1:0]  cnt_q, hlen_q;
  logic [INT_W-1:0]  int_q;
  logic [FRAC_W-1:0] num_q, den_q, acc_q;
  logic              active_q;

  logic              end_evt, mid_evt, start, take_live, changed;
  logic              dither, stretch;
  logic [INT_W-1:0]  u_int;
  logic [FRAC_W-1:0] u_num, u_den, base_acc, acc_nxt;
  logic [PRE_W-1:0]  u_pre;
  logic              u_lf;
  logic [SUM_W-1:0]  sum;
  logic [LEN_W-1:0]  len;

  always_comb begin
    end_evt   = active_q && (cnt_q == '0);
    mid_evt   = active_q && (cnt_q == hlen_q);
    start     = !active_q && en && !cfg_bad;
    take_live = start || (end_evt && pix_bound);
    changed   = {cfg_int, cfg_num, cfg_den, cfg_pre, cfg_launch_fall}
             != {int_q, num_q, den_q, pre_q, lf_q};
    u_int     = take_live ? cfg_int : int_q;
    u_num     = take_live ? cfg_num : num_q;
    u_den     = take_live ? cfg_den : den_q;
    u_pre     = take_live ? cfg_pre : pre_q;
    u_lf      = take_live ? cfg_launch_fall : lf_q;
    base_acc  = (start || (take_live && changed)) ? '0 : acc_q;
    dither    = (u_den != '0) && (u_num != '0);
    sum       = {1'b0, base_acc} + {1'b0, u_num};
    stretch   = dither && (sum >= {1'b0, u_den});
    if (!dither)      acc_nxt = '0;
    else if (stretch) acc_nxt = FRAC_W'(sum - {1'b0, u_den});
    else              acc_nxt = FRAC_W'(sum);
    len       = {1'b0, u_int} + LEN_W'(stretch);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      hlen_q   <= '0;
      int_q    <= '0;
      num_q    <= '0;
      den_q    <= '0;
      acc_q    <= '0;
      pre_q    <= '0;
      lf_q     <= 1'b0;
    end else if (!en) begin
      active_q <= 1'b0;
    end else if (start || (end_evt && !(pix_bound && cfg_bad))) begin
      active_q <= 1'b1;
      int_q    <= u_int;
      num_q    <= u_num;
      den_q    <= u_den;
      pre_q    <= u_pre;
      lf_q     <= u_lf;
      acc_q    <= acc_nxt;
      cnt_q    <= len - LEN_W'(1);
      hlen_q   <= len >> 1;
    end else if (end_evt) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      cnt_q    <= cnt_q - LEN_W'(1);
    end
  end

  always_comb begin
    active = active_q;
    if (end_evt)      ev = EV_END;
    else if (mid_evt) ev = EV_MID;
    else              ev = EV_NONE;
  end

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && cfg_bad) |=> !active_q); // R3
  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q <= {1'b0, int_q})); // R5
  AST_ACC_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && den_q != '0) |-> (acc_q < den_q)); // R5
  AST_MID_BEFORE_END: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (hlen_q != '0)); // R6
endmodule

// File: rtl/pixclk_prescale.sv
module pixclk_prescale
  import pixclk_pkg::*;
#(
  parameter int PRE_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  half_ev_e         ev,
  input  logic [PRE_W-1:0] pre_q,
  input  logic             lf_q,
  input  logic             idle_hi,
  output logic             pix_bound,
  output logic             pclk,
  output logic             launch_stb,
  output logic             sample_stb
);
  localparam int CNT_W = PRE_W + 1;

  logic [CNT_W-1:0] cnt_q, last, midp;
  logic             is_evt, flip;
  logic             pclk_q, lstb_q, sstb_q;

  always_comb begin
    last      = {pre_q, 1'b1};
    midp      = {1'b0, pre_q};
    is_evt    = (ev != EV_NONE);
    pix_bound = (ev == EV_END) && (cnt_q == last);
    flip      = run && is_evt && ((cnt_q == midp) || (cnt_q == last));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pclk_q <= 1'b0;
      lstb_q <= 1'b0;
      sstb_q <= 1'b0;
    end else if (!run) begin
      cnt_q  <= '0;
      pclk_q <= idle_hi;
      lstb_q <= 1'b0;
      sstb_q <= 1'b0;
    end else begin
      if (is_evt) cnt_q <= (cnt_q == last) ? '0 : cnt_q + CNT_W'(1);
      if (flip) pclk_q <= ~pclk_q;
      lstb_q <= flip && (pclk_q == lf_q);
      sstb_q <= flip && (pclk_q != lf_q);
    end
  end

  always_comb begin
    pclk       = pclk_q;
    launch_stb = lstb_q;
    sample_stb = sstb_q;
  end

  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(launch_stb && sample_stb)); // R8
  AST_STB_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_stb || sample_stb) |-> (pclk != $past(pclk))); // R8
  AST_CNT2_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= last)); // R7
endmodule

// File: rtl/pixclk_gen.sv
module pixclk_gen
  import pixclk_pkg::*;
#(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 6,
  parameter int PRE_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [INT_W-1:0]  cfg_int,
  input  logic [FRAC_W-1:0] cfg_num,
  input  logic [FRAC_W-1:0] cfg_den,
  input  logic [PRE_W-1:0]  cfg_pre,
  input  logic              cfg_idle_hi,
  input  logic              cfg_launch_fall,
  output logic              cfg_err,
  output logic              pclk,
  output logic              launch_stb,
  output logic              sample_stb
);
  logic             bad, active, pix_bound, run;
  half_ev_e         ev;
  logic [PRE_W-1:0] pre_q;
  logic             lf_q;

  pixclk_cfg_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
    .cfg_int (cfg_int),
    .cfg_num (cfg_num),
    .cfg_den (cfg_den),
    .cfg_bad (bad)
  );

  pixclk_frac_div #(.INT_W(INT_W), .FRAC_W(FRAC_W), .PRE_W(PRE_W)) u_div (
    .clk             (clk),
    .rst_n           (rst_n),
    .en              (en),
    .cfg_int         (cfg_int),
    .cfg_num         (cfg_num),
    .cfg_den         (cfg_den),
    .cfg_pre         (cfg_pre),
    .cfg_launch_fall (cfg_launch_fall),
    .cfg_bad         (bad),
    .pix_bound       (pix_bound),
    .active          (active),
    .ev              (ev),
    .pre_q           (pre_q),
    .lf_q            (lf_q)
  );

  assign run     = active && en;
  assign cfg_err = bad;

  pixclk_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .ev         (ev),
    .pre_q      (pre_q),
    .lf_q       (lf_q),
    .idle_hi    (cfg_idle_hi),
    .pix_bound  (pix_bound),
    .pclk       (pclk),
    .launch_stb (launch_stb),
    .sample_stb (sample_stb)
  );

  AST_GATED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pclk == $past(cfg_idle_hi) && !launch_stb && !sample_stb)); // R2
endmodule

// File: tb/pixclk_gen_test.sv
`timescale 1ns/1ps
module pixclk_gen_test;
  localparam int INT_W = 8, FRAC_W = 6, PRE_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [INT_W-1:0]  cfg_int = 8'd3;
  logic [FRAC_W-1:0] cfg_num = '0, cfg_den = '0;
  logic [PRE_W-1:0]  cfg_pre = '0;
  logic cfg_idle_hi = 1'b0, cfg_launch_fall = 1'b0;
  logic cfg_err, pclk, launch_stb, sample_stb;

  always #2.5 clk = ~clk;

  pixclk_gen #(.INT_W(INT_W), .FRAC_W(FRAC_W), .PRE_W(PRE_W)) uut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .cfg_int(cfg_int), .cfg_num(cfg_num), .cfg_den(cfg_den), .cfg_pre(cfg_pre),
    .cfg_idle_hi(cfg_idle_hi), .cfg_launch_fall(cfg_launch_fall),
    .cfg_err(cfg_err), .pclk(pclk), .launch_stb(launch_stb), .sample_stb(sample_stb)
  );

  int n_chk = 0, n_bad = 0;
  int exp_q[$];
  int edge_cnt = 0, last_edge = 0, launch_cnt = 0;
  int m_acc = 0, m_since = 0;
  bit sb_on = 1'b0, lf_exp = 1'b0, prev_pclk = 1'b0, done = 1'b0;

  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  task automatic check(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // Reference model of R4..R7: pushes expected gaps between pclk changes
  task automatic model(int ci, int cn, int cd, int cp, int periods, bit reset_acc);
    if (reset_acc) m_acc = 0;
    for (int p = 0; p < periods; p++) begin
      for (int q = 0; q <= cp; q++) begin
        bit dith, st;
        int sum, len, h;
        dith = (cd != 0) && (cn != 0);
        sum  = m_acc + cn;
        st   = dith && (sum >= cd);
        m_acc = !dith ? 0 : (st ? sum - cd : sum);
        len = ci + (st ? 1 : 0);
        h   = len / 2;
        m_since += len - h;
        if (2*q == cp) begin exp_q.push_back(m_since); m_since = 0; end
        m_since += h;
        if (2*q + 1 == cp || 2*q + 1 == 2*cp + 1) begin exp_q.push_back(m_since); m_since = 0; end
      end
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (sb_on) begin
      if (pclk != prev_pclk) begin
        int gap;
        bit want_l;
        gap = edge_cnt - last_edge;
        last_edge = edge_cnt;
        want_l = (pclk == !lf_exp);
        if (launch_stb) launch_cnt++;
        check(launch_stb == want_l && sample_stb == !want_l, "R8 strobe polarity",
              {launch_stb, sample_stb}, {want_l, !want_l});
        if (exp_q.size() == 0)
          check(1'b0, "R7 unexpected pclk change", gap, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          check(gap == e, "R7 pclk change gap (R4 R5 R6 R9)", gap, e);
        end
      end else if (launch_stb || sample_stb) begin
        check(1'b0, "R8 strobe without edge", {launch_stb, sample_stb}, 0);
      end
    end
    prev_pclk = pclk;
  end

  task automatic set_cfg(int ci, int cn, int cd, int cp, bit idle, bit lf);
    cfg_int = INT_W'(ci); cfg_num = FRAC_W'(cn); cfg_den = FRAC_W'(cd);
    cfg_pre = PRE_W'(cp); cfg_idle_hi = idle; cfg_launch_fall = lf; lf_exp = lf;
  endtask

  task automatic start_run();
    @(negedge clk); #1;
    m_since = 0; launch_cnt = 0;
    last_edge = edge_cnt + 1;
    sb_on = 1'b1;
    en = 1'b1;
  endtask

  task automatic stop_when_empty(string req);
    do begin @(negedge clk); #1; end while (exp_q.size() != 0);
    en = 1'b0;
    @(negedge clk); #1;
    sb_on = 1'b0;
    check(pclk == cfg_idle_hi, req, pclk, cfg_idle_hi);
  endtask

  task automatic run_case(int ci, int cn, int cd, int cp, bit idle, bit lf, int periods, string req);
    set_cfg(ci, cn, cd, cp, idle, lf);
    repeat (2) @(negedge clk);
    model(ci, cn, cd, cp, periods, 1'b1);
    start_run();
    stop_when_empty(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", edge_cnt, 0);
    finish_up();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(pclk == 1'b0 && !launch_stb && !sample_stb, "R1 reset outputs",
          {pclk, launch_stb, sample_stb}, 0);
    #1 rst_n = 1'b1;
    // R2: idle level follows cfg while gated
    cfg_idle_hi = 1'b1;
    repeat (2) @(negedge clk);
    check(pclk == 1'b1, "R2 idle high while gated", pclk, 1);
    #1 cfg_idle_hi = 1'b0;
    repeat (2) @(negedge clk);
    check(pclk == 1'b0, "R2 idle low while gated", pclk, 0);

    run_case(3, 0, 0, 0, 0, 0, 4, "R4 bypass int3 ends idle");
    run_case(4, 5, 0, 1, 0, 0, 3, "R4 den0 bypass ends idle");
    run_case(3, 1, 2, 0, 0, 0, 6, "R5 fraction 1/2 ends idle");
    run_case(2, 2, 3, 2, 1, 1, 5, "R8 idle-high launch-fall ends idle");
    run_case(5, 3, 7, 1, 0, 1, 4, "R6 fraction 3/7 ends idle");
    run_case(2, 0, 0, 63, 0, 0, 2, "R10 prescale 64 ends idle");

    // R9: change config after third launch edge, applies at pixel boundary
    set_cfg(3, 1, 3, 1, 0, 0);
    repeat (2) @(negedge clk);
    model(3, 1, 3, 1, 3, 1'b1);
    model(4, 1, 2, 0, 4, 1'b1);
    start_run();
    do begin @(negedge clk); #1; end while (launch_cnt < 3);
    set_cfg(4, 1, 2, 0, 0, 0);
    stop_when_empty("R9 midrun change ends idle");

    // R3: illegal configurations
    set_cfg(1, 0, 0, 0, 0, 0);
    #1 check(cfg_err == 1'b1, "R3 int below 2 flagged", cfg_err, 1);
    set_cfg(4, 3, 3, 0, 0, 0);
    #1 check(cfg_err == 1'b1, "R3 num>=den flagged", cfg_err, 1);
    set_cfg(2, 2, 3, 0, 0, 0);
    #1 check(cfg_err == 1'b0, "R3 legal cfg not flagged", cfg_err, 0);
    set_cfg(1, 0, 0, 0, 0, 0);
    start_run();
    repeat (30) @(negedge clk);
    #1 check(pclk == 1'b0 && exp_q.size() == 0, "R3 no clock with bad cfg", pclk, 0);
    en = 1'b0; sb_on = 1'b0;

    // R2: gating mid-run
    set_cfg(6, 0, 0, 3, 0, 0);
    repeat (2) @(negedge clk);
    @(negedge clk); #1 en = 1'b1;
    do begin @(negedge clk); #1; end while (pclk != 1'b1);
    en = 1'b0;
    @(negedge clk);
    check(pclk == 1'b0 && !launch_stb && !sample_stb, "R2 gated mid-run to idle", pclk, 0);

    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule